// File: doc/BRIEF.md
# Setpoint-Relative Voltage Threshold Monitor

The monitor takes a digitized output-voltage sample with a valid strobe and compares it against three limits. The limits are an undervoltage level, an overvoltage level and a lower power-good level. None of them is an absolute value: each is a percentage of the live output setpoint code. The setpoint code already contains any trim or margin offset. When that code moves, the absolute compare levels move with it on the next clock.

Two configuration bytes sit behind a simple write port that can be read back. The protection byte selects the percentage for each limit. The current-limit byte carries three things: a load-regulation code, a temperature-compensation enable, and a current-limit code that is clamped to its highest legal value. All three are forwarded to the regulation logic.

Each threshold is the setpoint multiplied by a Q8 constant, `floor(pct*256/100)`, and shifted right by 8. The result is held in a register. The flag registers update only on a sample strobe.

Top module: `vsense_thr_mon`

## Requirements
- R1: Undervoltage code (protection byte bits 1:0) selects 00=75 %, 01=80 %, 10=85 %, and 11 is also 85 %. Its reset value is 00.
- R2: Overvoltage code (protection byte bits 3:2) selects 00=110 %, 01=120 %, and both 10 and 11 select 130 %. Its reset value is 10.
- R3: Power-good level bit (protection byte bit 4) selects 0=90 % and 1=95 %. Its reset value is 0.
- R4: Each threshold equals `(setpoint * floor(pct*256/100)) >> 8`. It is registered from the setpoint and configuration present at a clock edge, so a setpoint change reaches the thresholds one cycle later.
- R5: `uv_o` is set when the strobed sample is strictly below the undervoltage threshold.
- R6: `ov_o` is set when the strobed sample is strictly above the overvoltage threshold.
- R7: `pg_o` is set when the strobed sample is at or above the power-good threshold and `ov_o` is not set, so the two never assert together.
- R8: The flags update on the clock edge at which `sample_vld_i` is high, compare against the thresholds registered at the previous edge, hold their value otherwise, and reset to 0.
- R9: The protection byte reads back with bits 7:5 as zero. Its reset readback is 0x08.
- R10: Current-limit byte layout: bits 7:5 hold the load-regulation code (reset 000), bit 4 holds the temperature-compensation enable (reset 1), and bits 3:0 hold the current-limit code (reset 0xB). A written code above 0xB is stored as 0xB. The reset readback is 0x1B. The outputs `lreg_o`, `tcomp_en_o` and `ilim_o` show the stored fields.
- R11: `cfg_sel_i`=0 addresses the protection byte and 1 addresses the current-limit byte. Readback is combinational. A byte changes only on a clock edge with `cfg_we_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | SAMPLE_W | Output-voltage sample code |
| sample_vld_i | input | 1 | Sample strobe |
| setpoint_i | input | SAMPLE_W | Active setpoint code |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 1 | Byte select: 0 protection, 1 current limit |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Readback of the selected byte |
| ilim_o | output | 4 | Clamped current-limit code |
| lreg_o | output | 3 | Load-regulation code |
| tcomp_en_o | output | 1 | Temperature-compensation enable |
| uv_o | output | 1 | Undervoltage flag |
| ov_o | output | 1 | Overvoltage flag |
| pg_o | output | 1 | Power-good flag |

## Verification
The bench builds the block with the default 12-bit sample and setpoint width. At that width the setpoint can rise high enough that the 130 % threshold no longer fits in 12 bits. This exercises the widened threshold path and gives a case where overvoltage can never trip. A cycle-accurate model tracks the one-cycle threshold register and the strobe-gated flags. Directed samples placed one code below, on, and one code above every threshold, for every configuration code, cover the strict and inclusive comparisons.

// File: rtl/vsense_thr_pkg.sv
package vsense_thr_pkg;
  localparam int K_W = 9;  // holds floor(130*256/100) = 332
  localparam logic [3:0] ILIM_MAX = 4'hB;

  typedef struct packed {
    logic       pg_hi;
    logic [1:0] ov_code;
    logic [1:0] uv_code;
  } prot_cfg_t;

  typedef struct packed {
    logic [2:0] lreg;
    logic       tcomp;
    logic [3:0] ilim;
  } ilim_cfg_t;

  function automatic logic [K_W-1:0] pct_q8(int unsigned pct);
    return K_W'((pct * 256) / 100);
  endfunction

  function automatic logic [K_W-1:0] uv_k(logic [1:0] code);
    case (code)
      2'b00:   return pct_q8(75);
      2'b01:   return pct_q8(80);
      default: return pct_q8(85);
    endcase
  endfunction

  function automatic logic [K_W-1:0] ov_k(logic [1:0] code);
    case (code)
      2'b00:   return pct_q8(110);
      2'b01:   return pct_q8(120);
      default: return pct_q8(130);
    endcase
  endfunction

  function automatic logic [K_W-1:0] pg_k(logic hi);
    return hi ? pct_q8(95) : pct_q8(90);
  endfunction
endpackage

// File: rtl/vsense_cfg_regs.sv
module vsense_cfg_regs
  import vsense_thr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       sel_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output prot_cfg_t  prot_o,
  output ilim_cfg_t  ilim_o
);
  prot_cfg_t prot_q;
  ilim_cfg_t ilim_q;
  logic [3:0] ilim_sat;

  assign ilim_sat = (wdata_i[3:0] > ILIM_MAX) ? ILIM_MAX : wdata_i[3:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= '{pg_hi: 1'b0, ov_code: 2'b10, uv_code: 2'b00};
      ilim_q <= '{lreg: 3'b000, tcomp: 1'b1, ilim: ILIM_MAX};
    end else if (we_i) begin
      if (sel_i) ilim_q <= '{lreg: wdata_i[7:5], tcomp: wdata_i[4], ilim: ilim_sat};
      else       prot_q <= prot_cfg_t'(wdata_i[4:0]);
    end
  end

  assign rdata_o = sel_i ? ilim_q : {3'b000, prot_q};
  assign prot_o  = prot_q;
  assign ilim_o  = ilim_q;
endmodule

// File: rtl/vsense_thr_scale.sv
module vsense_thr_scale #(
  parameter int W   = 12,
  parameter int K_W = 9,
  localparam int PW = W + K_W,
  localparam int TW = PW - 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   sp_i,
  input  logic [K_W-1:0] k_i,
  output logic [TW-1:0]  thr_o
);
  logic [PW-1:0] prod;
  assign prod = PW'(sp_i) * PW'(k_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_o <= '0;
    else         thr_o <= prod[PW-1:8];
  end
endmodule

// File: rtl/vsense_flag_eval.sv
module vsense_flag_eval #(
  parameter int W  = 12,
  parameter int TW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [W-1:0]  sample_i,
  input  logic [TW-1:0] uv_thr_i,
  input  logic [TW-1:0] ov_thr_i,
  input  logic [TW-1:0] pg_thr_i,
  output logic          uv_o,
  output logic          ov_o,
  output logic          pg_o
);
  logic [TW-1:0] s_ext;
  logic uv_d, ov_d, pg_d;

  assign s_ext = TW'(sample_i);
  assign uv_d  = s_ext < uv_thr_i;
  assign ov_d  = s_ext > ov_thr_i;
  assign pg_d  = (s_ext >= pg_thr_i) && !ov_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uv_o <= 1'b0;
      ov_o <= 1'b0;
      pg_o <= 1'b0;
    end else if (vld_i) begin
      uv_o <= uv_d;
      ov_o <= ov_d;
      pg_o <= pg_d;
    end
  end
endmodule

// File: rtl/vsense_thr_mon.sv
module vsense_thr_mon
  import vsense_thr_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_vld_i,
  input  logic [SAMPLE_W-1:0] setpoint_i,
  input  logic                cfg_we_i,
  input  logic                cfg_sel_i,
  input  logic [7:0]          cfg_wdata_i,
  output logic [7:0]          cfg_rdata_o,
  output logic [3:0]          ilim_o,
  output logic [2:0]          lreg_o,
  output logic                tcomp_en_o,
  output logic                uv_o,
  output logic                ov_o,
  output logic                pg_o
);
  localparam int TW    = SAMPLE_W + K_W - 8;
  localparam int N_THR = 3;  // 0 uv, 1 ov, 2 pg

  prot_cfg_t prot;
  ilim_cfg_t ilim;
  logic [K_W-1:0] k_sel [N_THR];
  logic [TW-1:0]  thr   [N_THR];

  vsense_cfg_regs u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .prot_o  (prot),
    .ilim_o  (ilim)
  );

  assign k_sel[0] = uv_k(prot.uv_code);
  assign k_sel[1] = ov_k(prot.ov_code);
  assign k_sel[2] = pg_k(prot.pg_hi);

  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    vsense_thr_scale #(.W(SAMPLE_W), .K_W(K_W)) u_scale (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sp_i   (setpoint_i),
      .k_i    (k_sel[g]),
      .thr_o  (thr[g])
    );
  end

  vsense_flag_eval #(.W(SAMPLE_W), .TW(TW)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (sample_vld_i),
    .sample_i (sample_i),
    .uv_thr_i (thr[0]),
    .ov_thr_i (thr[1]),
    .pg_thr_i (thr[2]),
    .uv_o     (uv_o),
    .ov_o     (ov_o),
    .pg_o     (pg_o)
  );

  assign ilim_o     = ilim.ilim;
  assign lreg_o     = ilim.lreg;
  assign tcomp_en_o = ilim.tcomp;
endmodule

// File: rtl/vsense_thr_mon_chk.sv
module vsense_thr_mon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sample_vld_i,
  input logic       cfg_we_i,
  input logic       cfg_sel_i,
  input logic [7:0] cfg_wdata_i,
  input logic [7:0] cfg_rdata_o,
  input logic [3:0] ilim_o,
  input logic       tcomp_en_o,
  input logic       uv_o,
  input logic       ov_o,
  input logic       pg_o
);
  // R10
  ilim_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) ilim_o <= 4'hB);

  // R9
  unimpl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_sel_i |-> cfg_rdata_o[7:5] == 3'b000);

  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |=> $stable({uv_o, ov_o, pg_o}));

  // R7
  pg_excl_ov_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !(pg_o && ov_o));

  // R5
  uv_excl_ov_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !(uv_o && ov_o));

  // R10
  tcomp_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_sel_i |=> tcomp_en_o == $past(cfg_wdata_i[4]));
endmodule

bind vsense_thr_mon vsense_thr_mon_chk u_chk (.*);

// File: tb/tb_vsense_thr_mon.sv
module tb_vsense_thr_mon;
  localparam int W = 12;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] sample_i = '0;
  logic         sample_vld_i = 1'b0;
  logic [W-1:0] setpoint_i = '0;
  logic         cfg_we_i = 1'b0;
  logic         cfg_sel_i = 1'b0;
  logic [7:0]   cfg_wdata_i = '0;
  logic [7:0]   cfg_rdata_o;
  logic [3:0]   ilim_o;
  logic [2:0]   lreg_o;
  logic         tcomp_en_o, uv_o, ov_o, pg_o;

  int n_chk = 0;
  int n_fail = 0;

  vsense_thr_mon #(.SAMPLE_W(W)) dut (.*);

  always #5 clk_i = ~clk_i;  // 100 MHz

  // reference model state
  int m_prot, m_ilim, m_thr_uv, m_thr_ov, m_thr_pg;
  bit m_uv, m_ov, m_pg;

  function automatic int pct_thr(int sp, int pct);
    return (sp * ((pct * 256) / 100)) / 256;
  endfunction

  function automatic int uv_pct(int p);
    int c = p & 3;
    return (c == 0) ? 75 : (c == 1) ? 80 : 85;
  endfunction
  function automatic int ov_pct(int p);
    int c = (p >> 2) & 3;
    return (c == 0) ? 110 : (c == 1) ? 120 : 130;
  endfunction
  function automatic int pg_pct(int p);
    return ((p >> 4) & 1) ? 95 : 90;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_prot = 8'h08; m_ilim = 8'h1B;
      m_thr_uv = 0; m_thr_ov = 0; m_thr_pg = 0;
      m_uv = 0; m_ov = 0; m_pg = 0;
    end else begin
      int s, lim;
      s = int'(sample_i);
      if (sample_vld_i) begin
        m_uv = s < m_thr_uv;
        m_ov = s > m_thr_ov;
        m_pg = (s >= m_thr_pg) && !m_ov;
      end
      m_thr_uv = pct_thr(int'(setpoint_i), uv_pct(m_prot));
      m_thr_ov = pct_thr(int'(setpoint_i), ov_pct(m_prot));
      m_thr_pg = pct_thr(int'(setpoint_i), pg_pct(m_prot));
      if (cfg_we_i) begin
        if (cfg_sel_i) begin
          lim = int'(cfg_wdata_i) & 15;
          if (lim > 11) lim = 11;
          m_ilim = (int'(cfg_wdata_i) & 8'hF0) | lim;
        end else m_prot = int'(cfg_wdata_i) & 8'h1F;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s t=%0t act=%0h exp=%0h", tag, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk_i) begin
    chk("R1 R5 R8 uv_o", int'(uv_o), int'(m_uv));
    chk("R2 R6 R8 ov_o", int'(ov_o), int'(m_ov));
    chk("R3 R4 R7 pg_o", int'(pg_o), int'(m_pg));
    chk("R9 R11 rdata", int'(cfg_rdata_o), cfg_sel_i ? m_ilim : m_prot);
    chk("R10 ilim_o", int'(ilim_o), m_ilim & 15);
    chk("R10 lreg_o", int'(lreg_o), (m_ilim >> 5) & 7);
    chk("R10 tcomp_en_o", int'(tcomp_en_o), (m_ilim >> 4) & 1);
  end

  task automatic tick();
    @(posedge clk_i); #2;
    cfg_we_i = 1'b0;
    sample_vld_i = 1'b0;
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    cfg_sel_i = sel; cfg_wdata_i = d; cfg_we_i = 1'b1;
    tick();
  endtask

  task automatic strobe(int s);
    sample_i = W'(s); sample_vld_i = 1'b1;
    tick();
  endtask

  // samples one below, on and one above a threshold
  task automatic probe3(int thr);
    for (int d = -1; d <= 1; d++) begin
      int s = thr + d;
      if (s >= 0 && s < (1 << W)) strobe(s);
    end
    tick();
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int sp;
    #12 rst_ni = 1'b1;
    tick();
    // R9 R10 reset readback
    cfg_sel_i = 1'b0; #1; chk("R9 reset prot", int'(cfg_rdata_o), 8'h08);
    cfg_sel_i = 1'b1; #1; chk("R10 reset ilim", int'(cfg_rdata_o), 8'h1B);
    // R10 saturation for every code
    for (int c = 0; c < 16; c++) begin
      wr(1'b1, 8'(8'hA0 | c));
      chk("R10 sat", int'(ilim_o), (c > 11) ? 11 : c);
    end
    // R11 no write without enable
    cfg_sel_i = 1'b1; cfg_wdata_i = 8'h00; tick();
    chk("R11 no we", int'(cfg_rdata_o), 8'hAB);
    wr(1'b0, 8'hFF);
    cfg_sel_i = 1'b0; #1; chk("R9 unimpl", int'(cfg_rdata_o), 8'h1F);
    // R1 R2 R3 R4 R5 R6 R7: every code, boundary samples
    sp = 2000;
    setpoint_i = W'(sp);
    for (int p = 0; p < 32; p++) begin
      wr(1'b0, 8'(p));
      tick();
      probe3(pct_thr(sp, uv_pct(p)));
      probe3(pct_thr(sp, ov_pct(p)));
      probe3(pct_thr(sp, pg_pct(p)));
    end
    // R4 setpoint change takes effect one cycle later
    wr(1'b0, 8'h00);
    setpoint_i = W'(1000); tick();
    setpoint_i = W'(3000); strobe(760);
    strobe(760);
    // R4 high setpoint: 130 % exceeds sample range
    setpoint_i = W'(4095); wr(1'b0, 8'h08); tick();
    strobe(4095);
    chk("R6 ov unreachable", int'(ov_o), 0);
    // random traffic
    for (int i = 0; i < 6000; i++) begin
      setpoint_i  = ($urandom_range(0, 7) == 0) ? W'($urandom) : setpoint_i;
      sample_i    = W'($urandom_range(0, 4095));
      sample_vld_i = $urandom_range(0, 1);
      cfg_sel_i   = $urandom_range(0, 1);
      cfg_wdata_i = 8'($urandom);
      cfg_we_i    = ($urandom_range(0, 15) == 0);
      @(posedge clk_i); #2;
    end
    cfg_we_i = 1'b0; sample_vld_i = 1'b0;
    tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule